// File: doc/BRIEF.md
# Operand Address Generator

This block turns the addressing fields of a memory operand into a bus address. From a mode code, four pointer register values (BX, BP, SI, DI) and a displacement, it forms a 16-bit effective offset. It then adds a segment base, taken from one of two segment inputs, to make a 20-bit physical address. The segment is chosen by a default rule: any form that involves BP uses the stack segment, and every other form uses the data segment. A status bit reports which of the two was used.

Requests enter on a valid/ready handshake and results leave on another. A parameter picks one of two output styles. With a registered output, each request is held in one slot and appears one cycle after it is accepted. Without it, the path is purely combinational and ready and valid pass straight through. While a result is offered but not taken, it stays frozen, and the input is refused unless the slot is about to empty.

Top module: `operand_addr_gen`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Mode 0 (direct) gives an offset equal to the displacement and uses the data segment.
- R3: Mode 1 (pointer indirect) gives an offset equal to the register picked by `in_ind_sel` (0 BX, 1 BP, 2 SI, 3 DI).
- R4: Mode 2 (based) gives base plus displacement, where `in_base_sel` 0 picks BX and 1 picks BP.
- R5: Mode 3 (indexed) gives index plus displacement, where `in_idx_sel` 0 picks SI and 1 picks DI.
- R6: Mode 4 (based-indexed) gives base plus index.
- R7: Mode 5 (based-indexed with displacement) gives base plus index plus displacement.
- R8: When `in_disp_wide` is 1, the displacement is all 16 bits of `in_disp`. When it is 0, the displacement is `in_disp[7:0]` sign-extended to 16 bits, and `in_disp[15:8]` has no effect.
- R9: The offset sum wraps modulo 2^16.
- R10: `out_pa` equals (segment × 16 + offset) modulo 2^20.
- R11: `out_stack_seg` is 1 and the segment is `in_ss` exactly when BP enters the sum. This is the case for mode 1 with select 1, and for modes 2, 4 and 5 with `in_base_sel`=1. Otherwise `out_stack_seg` is 0 and the segment is `in_ds`.
- R12: Mode codes 6 and 7 behave as direct mode.
- R13: A request is taken on a clock where `in_valid` and `in_ready` are both high. In the registered style:
  - `in_ready` equals `!out_valid || out_ready`.
  - A result is valid one cycle after it is taken.
  - A result that is offered but not accepted holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with `in_valid` |
| in_mode | input | 3 | Addressing mode code |
| in_base_sel | input | 1 | Base register pick: 0 BX, 1 BP |
| in_idx_sel | input | 1 | Index register pick: 0 SI, 1 DI |
| in_ind_sel | input | 2 | Pointer pick for mode 1 |
| in_disp_wide | input | 1 | 1: 16-bit displacement, 0: sign-extended 8-bit |
| in_disp | input | 16 | Displacement / direct offset |
| in_bx | input | 16 | BX value |
| in_bp | input | 16 | BP value |
| in_si | input | 16 | SI value |
| in_di | input | 16 | DI value |
| in_ds | input | 16 | Data segment value |
| in_ss | input | 16 | Stack segment value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_ea | output | 16 | Effective offset |
| out_pa | output | 20 | Physical address |
| out_stack_seg | output | 1 | 1 when the stack segment was used |

## Verification
Each mode is first driven with distinct register values, so that a wrong register pick or a missing term gives a different sum. Each base and index select is tried at both settings, which exposes swapped selects and wrong segment choices.

Short displacements are tried with bit 7 set and with junk in the upper byte; these cases separate sign extension from zero padding and from use of the full field. Sums past 0xFFFF and segment bases near the top of the space show whether each adder truncates at the right width. Randomized requests under random back-pressure compare the handshake and the held output, cycle by cycle, against a queue model.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT        = 3'd0,
    AM_REG_IND       = 3'd1,
    AM_BASED         = 3'd2,
    AM_INDEXED       = 3'd3,
    AM_BASE_IDX      = 3'd4,
    AM_BASE_IDX_DISP = 3'd5
  } am_mode_e;

  localparam int PTR_BX = 0;
  localparam int PTR_BP = 1;
  localparam int PTR_SI = 2;
  localparam int PTR_DI = 3;
endpackage

// File: rtl/opaddr_ea_calc.sv
module opaddr_ea_calc
  import opaddr_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic [2:0]       mode,
  input  logic             base_sel,
  input  logic             idx_sel,
  input  logic [1:0]       ind_sel,
  input  logic             disp_wide,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] bx,
  input  logic [OFS_W-1:0] bp,
  input  logic [OFS_W-1:0] si,
  input  logic [OFS_W-1:0] di,
  output logic [OFS_W-1:0] ea,
  output logic             use_bp
);
  localparam int EXT_W = OFS_W - SHORT_W;

  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] base_v;
  logic [OFS_W-1:0] idx_v;
  logic [OFS_W-1:0] ind_v;
  logic [OFS_W-1:0] term_a;
  logic [OFS_W-1:0] term_b;
  logic [OFS_W-1:0] term_c;
  am_mode_e         m;

  always_comb begin
    disp_ext = disp_wide ? disp : {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    base_v   = base_sel ? bp : bx;
    idx_v    = idx_sel ? di : si;
    case (int'(ind_sel))
      PTR_BX:  ind_v = bx;
      PTR_BP:  ind_v = bp;
      PTR_SI:  ind_v = si;
      default: ind_v = di;
    endcase
  end

  always_comb begin
    m      = am_mode_e'(mode);
    term_a = '0;
    term_b = '0;
    term_c = '0;
    use_bp = 1'b0;
    case (m)
      AM_REG_IND: begin
        term_a = ind_v;
        use_bp = (int'(ind_sel) == PTR_BP);
      end
      AM_BASED: begin
        term_a = base_v;
        term_c = disp_ext;
        use_bp = base_sel;
      end
      AM_INDEXED: begin
        term_b = idx_v;
        term_c = disp_ext;
      end
      AM_BASE_IDX: begin
        term_a = base_v;
        term_b = idx_v;
        use_bp = base_sel;
      end
      AM_BASE_IDX_DISP: begin
        term_a = base_v;
        term_b = idx_v;
        term_c = disp_ext;
        use_bp = base_sel;
      end
      default: term_c = disp_ext;
    endcase
    ea = term_a + term_b + term_c;
  end
endmodule

// File: rtl/opaddr_pa_calc.sv
module opaddr_pa_calc #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic [OFS_W-1:0] ea,
  input  logic             use_bp,
  input  logic [OFS_W-1:0] ds,
  input  logic [OFS_W-1:0] ss,
  output logic [PA_W-1:0]  pa
);
  logic [OFS_W-1:0] seg;
  logic [PA_W-1:0]  seg_base;

  always_comb begin
    seg      = use_bp ? ss : ds;
    seg_base = PA_W'(seg) << SEG_SHIFT;
    pa       = seg_base + PA_W'(ea);
  end
endmodule

// File: rtl/opaddr_out_stage.sv
module opaddr_out_stage #(
  parameter int W       = 37,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_valid && in_ready) begin
          v_q <= 1'b1;
          d_q <= in_data;
        end else if (out_ready) begin
          v_q <= 1'b0;
        end
      end
      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SHORT_W   = 8,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_mode,
  input  logic             in_base_sel,
  input  logic             in_idx_sel,
  input  logic [1:0]       in_ind_sel,
  input  logic             in_disp_wide,
  input  logic [OFS_W-1:0] in_disp,
  input  logic [OFS_W-1:0] in_bx,
  input  logic [OFS_W-1:0] in_bp,
  input  logic [OFS_W-1:0] in_si,
  input  logic [OFS_W-1:0] in_di,
  input  logic [OFS_W-1:0] in_ds,
  input  logic [OFS_W-1:0] in_ss,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFS_W-1:0] out_ea,
  output logic [PA_W-1:0]  out_pa,
  output logic             out_stack_seg
);
  localparam int RES_W = OFS_W + PA_W + 1;

  logic [OFS_W-1:0] ea_c;
  logic             use_bp_c;
  logic [PA_W-1:0]  pa_c;
  logic [RES_W-1:0] res_in;
  logic [RES_W-1:0] res_out;

  opaddr_ea_calc #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ea (
    .mode(in_mode), .base_sel(in_base_sel), .idx_sel(in_idx_sel),
    .ind_sel(in_ind_sel), .disp_wide(in_disp_wide), .disp(in_disp),
    .bx(in_bx), .bp(in_bp), .si(in_si), .di(in_di),
    .ea(ea_c), .use_bp(use_bp_c)
  );

  opaddr_pa_calc #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_pa (
    .ea(ea_c), .use_bp(use_bp_c), .ds(in_ds), .ss(in_ss), .pa(pa_c)
  );

  assign res_in = {use_bp_c, pa_c, ea_c};

  opaddr_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_out)
  );

  assign out_ea        = res_out[OFS_W-1:0];
  assign out_pa        = res_out[OFS_W +: PA_W];
  assign out_stack_seg = res_out[RES_W-1];
endmodule

// File: rtl/operand_addr_gen_chk.sv
module operand_addr_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20,
  parameter bit REG_OUT   = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OFS_W-1:0] out_ea,
  input logic [PA_W-1:0]  out_pa,
  input logic             out_stack_seg
);
  localparam logic [PA_W-1:0] LOW_MASK = PA_W'((1 << SEG_SHIFT) - 1);

  logic [PA_W-1:0] seg_part;
  assign seg_part = out_pa - PA_W'(out_ea);

  // R10: the distance from offset to physical address is a whole paragraph
  p_pa_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((seg_part & LOW_MASK) == '0));

  generate
    if (REG_OUT) begin : g_reg_chk
      p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

      p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(out_ea) && $stable(out_pa) && $stable(out_stack_seg)));

      p_ready_free_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      p_take_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    end else begin : g_wire_chk
      p_pass_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == in_valid) && (in_ready == out_ready));
    end
  endgenerate
endmodule

bind operand_addr_gen operand_addr_gen_chk #(
  .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
  .out_pa(out_pa), .out_stack_seg(out_stack_seg)
);

// File: tb/operand_addr_gen_bench.sv
module operand_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic        in_base_sel = 1'b0;
  logic        in_idx_sel = 1'b0;
  logic [1:0]  in_ind_sel = '0;
  logic        in_disp_wide = 1'b0;
  logic [15:0] in_disp = '0, in_bx = '0, in_bp = '0, in_si = '0, in_di = '0;
  logic [15:0] in_ds = '0, in_ss = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_ea;
  logic [19:0] out_pa;
  logic        out_stack_seg;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "";
  bit    rand_ready = 1'b0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  operand_addr_gen u_operand_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base_sel(in_base_sel), .in_idx_sel(in_idx_sel),
    .in_ind_sel(in_ind_sel), .in_disp_wide(in_disp_wide), .in_disp(in_disp),
    .in_bx(in_bx), .in_bp(in_bp), .in_si(in_si), .in_di(in_di),
    .in_ds(in_ds), .in_ss(in_ss), .out_valid(out_valid), .out_ready(out_ready),
    .out_ea(out_ea), .out_pa(out_pa), .out_stack_seg(out_stack_seg)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic void ref_calc(input int md, input int bs, input int is, input int ns,
                                   input int wd, input int d, input int bx, input int bp,
                                   input int si, input int di, input int ds, input int ss,
                                   output int ea, output int pa, output int stk);
    int dv, base, idx, seg;
    dv   = wd ? d : (((d & 'h80) != 0) ? ((d & 'hFF) | 'hFF00) : (d & 'hFF));
    base = bs ? bp : bx;
    idx  = is ? di : si;
    stk  = 0;
    case (md)
      1: begin
        ea  = (ns == 0) ? bx : (ns == 1) ? bp : (ns == 2) ? si : di;
        stk = (ns == 1) ? 1 : 0;
      end
      2: begin ea = base + dv;       stk = bs; end
      3: begin ea = idx + dv;                  end
      4: begin ea = base + idx;      stk = bs; end
      5: begin ea = base + idx + dv; stk = bs; end
      default: ea = dv;
    endcase
    ea  = ea & 'hFFFF;
    seg = stk ? ss : ds;
    pa  = (seg * 16 + ea) & 'hFFFFF;
  endfunction

  function automatic string mode_tag(input int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R12";
    endcase
  endfunction

  // Reference model: one slot, updated from handshakes seen before each edge
  bit    m_valid = 1'b0;
  int    m_ea, m_pa, m_stk;
  string m_tag;
  bit    p_load = 1'b0, p_pop = 1'b0;
  int    p_ea, p_pa, p_stk;
  string p_tag;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        m_valid = 1'b0; p_load = 1'b0; p_pop = 1'b0;
      end else begin
        if (p_load) begin
          m_valid = 1'b1; m_ea = p_ea; m_pa = p_pa; m_stk = p_stk; m_tag = p_tag;
        end else if (p_pop) begin
          m_valid = 1'b0;
        end
        check("R13 in_ready", longint'(in_ready), longint'(!m_valid || out_ready));
        check("R13 out_valid", longint'(out_valid), longint'(m_valid));
        if (m_valid && out_valid) begin
          check({m_tag, " ea"}, longint'(out_ea), longint'(m_ea));
          check("R10 pa", longint'(out_pa), longint'(m_pa));
          check("R11 stack_seg", longint'(out_stack_seg), longint'(m_stk));
        end
        p_pop  = m_valid && out_ready;
        p_load = in_valid && (!m_valid || out_ready);
        if (p_load) begin
          ref_calc(int'(in_mode), int'(in_base_sel), int'(in_idx_sel), int'(in_ind_sel),
                   int'(in_disp_wide), int'(in_disp), int'(in_bx), int'(in_bp),
                   int'(in_si), int'(in_di), int'(in_ds), int'(in_ss), p_ea, p_pa, p_stk);
          p_tag = (cur_tag != "") ? cur_tag : mode_tag(int'(in_mode));
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rand_ready) out_ready = (($urandom % 4) != 0);
    end
  end

  task automatic send(input int md, input int bs, input int is, input int ns, input int wd,
                      input int d, input int bx, input int bp, input int si, input int di,
                      input int ds, input int ss, input string tag);
    bit acc;
    in_mode = 3'(md); in_base_sel = 1'(bs); in_idx_sel = 1'(is); in_ind_sel = 2'(ns);
    in_disp_wide = 1'(wd); in_disp = 16'(d); in_bx = 16'(bx); in_bp = 16'(bp);
    in_si = 16'(si); in_di = 16'(di); in_ds = 16'(ds); in_ss = 16'(ss);
    cur_tag = tag;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #2;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, ready even with the output not taken
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 in_ready", longint'(in_ready), 1);
    @(posedge clk);
    #2;
    out_ready = 1'b1;
    // R2..R7 with distinct register values, both selects
    send(0, 0, 0, 0, 1, 'h1234, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R2");
    for (int k = 0; k < 4; k++)
      send(1, 0, 0, k, 1, 'h0500, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R3");
    send(2, 0, 0, 0, 1, 'h0010, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R4");
    send(2, 1, 0, 0, 1, 'h0010, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R4");
    send(3, 0, 0, 0, 1, 'h0020, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R5");
    send(3, 0, 1, 0, 1, 'h0020, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R5");
    send(4, 1, 1, 0, 1, 'h0000, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R6");
    send(4, 0, 0, 0, 1, 'h0000, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R6");
    send(5, 1, 0, 0, 1, 'h0101, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R7");
    // R8: short displacement sign extension, upper byte ignored
    send(2, 0, 0, 0, 0, 'h5580, 'h0100, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R8");
    send(2, 0, 0, 0, 0, 'hAA7F, 'h0100, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R8");
    send(3, 0, 1, 0, 1, 'h8000, 'h0100, 'h2222, 'h3333, 'h0001, 'h1000, 'h2000, "R8");
    // R9: offset wrap
    send(4, 0, 0, 0, 1, 0, 'hFFFF, 0, 'h0002, 0, 'h1000, 'h2000, "R9");
    send(5, 1, 1, 0, 1, 'hFFFF, 0, 'hFFFF, 0, 'h8000, 'h1000, 'h2000, "R9");
    // R10: physical wrap near the top of the space
    send(0, 0, 0, 0, 1, 'h0020, 0, 0, 0, 0, 'hFFFF, 'h0000, "R10");
    // R12: spare codes behave as direct
    send(6, 1, 1, 1, 1, 'h4321, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R12");
    send(7, 1, 1, 1, 0, 'h00F0, 'h1111, 'h2222, 'h3333, 'h4444, 'h1000, 'h2000, "R12");
    // R13: random traffic under back-pressure
    rand_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      send(int'($urandom % 8), int'($urandom % 2), int'($urandom % 2), int'($urandom % 4),
           int'($urandom % 2), int'($urandom % 65536), int'($urandom % 65536),
           int'($urandom % 65536), int'($urandom % 65536), int'($urandom % 65536),
           int'($urandom % 65536), int'($urandom % 65536), "");
      if (($urandom % 3) == 0) begin
        @(posedge clk);
        #2;
      end
    end
    rand_ready = 1'b0;
    out_ready = 1'b1;
    repeat (10) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule